// File: doc/BRIEF.md
# Variable-Amount Shifter with Carry Flag

This block shifts or rotates a 32-bit operand by an amount taken from an 8-bit register byte, so the amount can be anything from 0 to 255. It supports four operations: logical left, logical right, arithmetic right and rotate right. Along with the shifted value it produces the bit last shifted out as the new carry, and a strobe that says whether the carry flag should be written at all.

The edge cases are the point of the block. A plain barrel shifter only sees the low five bits of the amount. Here an amount of zero passes both the operand and the carry through. Amounts of exactly 32 and amounts above 32 each have their own result and carry rule. A rotate by a nonzero multiple of 32 leaves the value as it is but still updates the carry. The datapath is combinational. A parameter adds one output register stage, which is on by default, and that stage clears to zero on reset.

Top module: `shift_carry_unit`

## Requirements
- R1: When the amount is 0, for every shift type, the result equals the operand, carryOut equals carryIn and carryWe is low.
- R2: Logical left (shiftType 2'b00) by n in 1..31 gives operand << n with carryOut = operand[32-n].
- R3: Logical left by exactly 32 gives result 0 with carryOut = operand[0]; by 33..255 it gives result 0 with carryOut 0.
- R4: Logical right (shiftType 2'b01) by n in 1..31 gives operand >> n, zero filled, with carryOut = operand[n-1].
- R5: Logical right by exactly 32 gives result 0 with carryOut = operand[31]; by 33..255 it gives result 0 with carryOut 0.
- R6: Arithmetic right (shiftType 2'b10) by n in 1..31 fills the vacated high bits with operand[31] and gives carryOut = operand[n-1].
- R7: Arithmetic right by 32..255 gives a result with every bit equal to operand[31], and carryOut = operand[31].
- R8: Rotate right (shiftType 2'b11) uses the amount modulo 32. When that value m is nonzero, the result is the operand rotated right by m and carryOut = operand[m-1].
- R9: A rotate right whose amount is a nonzero multiple of 32 (32, 64, ..., 224) returns the operand unchanged with carryOut = operand[31].
- R10: carryWe is high exactly when the amount is nonzero, for every shift type.
- R11: With the output register enabled (REG_OUT=1), the outputs reflect the inputs sampled at the previous rising clock edge, and while rstN is low all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset of the output register |
| operand | input | 32 | Value to be shifted or rotated |
| amount | input | 8 | Shift amount, 0 to 255 |
| shiftType | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carryIn | input | 1 | Current carry flag |
| result | output | 32 | Shifted or rotated value |
| carryOut | output | 1 | New carry flag value |
| carryWe | output | 1 | High when the carry flag is to be written |

## Verification
The bound checker checks several rules on every cycle: the zero-amount pass-through, the carry-write strobe, the fixed results for logical shifts by 32 and above, the sign fill of arithmetic shifts by 32 and above, and the rotate by a multiple of 32. The ordinary 1..31 shift and rotate results, the carry bit chosen for each amount, the one-cycle latency and the cleared state during reset can only be shown by the bench. It runs directed corner amounts and a pseudo-random sweep of all 256 amounts against its reference model.

// File: rtl/shift_carry_pkg.sv
package shift_carry_pkg;

  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SHIFT_LSL = 2'b00,
    SHIFT_LSR = 2'b01,
    SHIFT_ASR = 2'b10,
    SHIFT_ROR = 2'b11
  } shiftKind_e;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic             passThru;   // amount is zero
    logic             selLeft;    // logical left
    logic             selArith;   // arithmetic right
    logic             selRot;     // rotate right
    logic             fullOut;    // shift by DATA_W or more (non-rotate)
    logic             carryClr;   // carry forced to zero
    logic [IDX_W-1:0] rotRight;   // rotator distance
    logic [IDX_W-1:0] maskAmt;    // amount used for fill masks
    logic [IDX_W-1:0] carryIdx;   // bit of operand that becomes carry
  } shiftStrobes_t;

endpackage

// File: rtl/shift_carry_ctrl.sv
module shift_carry_ctrl
  import shift_carry_pkg::*;
#(
  parameter int AMT_W = 8
) (
  input  logic [AMT_W-1:0] amount,
  input  logic [1:0]       shiftType,
  output shiftStrobes_t    strobes
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(DATA_W - 1);

  logic             amtZero;
  logic             amtExact;
  logic             amtOver;
  logic [IDX_W-1:0] lowAmt;
  logic [IDX_W-1:0] negAmt;
  logic [IDX_W-1:0] lowMinus1;
  shiftKind_e       kind;

  always_comb begin
    kind      = shiftKind_e'(shiftType);
    amtZero   = (amount == '0);
    amtExact  = (amount == FULL_AMT);
    amtOver   = (amount > FULL_AMT);
    lowAmt    = amount[IDX_W-1:0];
    negAmt    = IDX_W'(~lowAmt + 1'b1);
    lowMinus1 = IDX_W'(lowAmt - 1'b1);
  end

  always_comb begin
    strobes          = '0;
    strobes.passThru = amtZero;
    strobes.maskAmt  = lowAmt;
    unique case (kind)
      SHIFT_LSL: begin
        strobes.selLeft  = 1'b1;
        strobes.fullOut  = amtExact | amtOver;
        strobes.carryClr = amtOver;
        strobes.rotRight = negAmt;
        strobes.carryIdx = amtExact ? '0 : negAmt;
      end
      SHIFT_LSR: begin
        strobes.fullOut  = amtExact | amtOver;
        strobes.carryClr = amtOver;
        strobes.rotRight = lowAmt;
        strobes.carryIdx = (amtExact | amtOver) ? TOP_IDX : lowMinus1;
      end
      SHIFT_ASR: begin
        strobes.selArith = 1'b1;
        strobes.fullOut  = amtExact | amtOver;
        strobes.rotRight = lowAmt;
        strobes.carryIdx = (amtExact | amtOver) ? TOP_IDX : lowMinus1;
      end
      default: begin
        strobes.selRot   = 1'b1;
        strobes.rotRight = lowAmt;
        // a multiple of DATA_W wraps to the top bit
        strobes.carryIdx = lowMinus1;
      end
    endcase
  end

endmodule

// File: rtl/shift_carry_rotator.sv
module shift_carry_rotator #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [IW-1:0] rot,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [0:IW];

  assign stage[0] = din;

  genvar s;
  generate
    for (s = 0; s < IW; s++) begin : gStage
      localparam int STEP = 1 << s;
      assign stage[s+1] = rot[s] ? {stage[s][STEP-1:0], stage[s][W-1:STEP]}
                                 : stage[s];
    end
  endgenerate

  assign dout = stage[IW];

endmodule

// File: rtl/shift_carry_datapath.sv
module shift_carry_datapath
  import shift_carry_pkg::*;
(
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  shiftStrobes_t     strobes,
  output logic [DATA_W-1:0] resultComb,
  output logic              carryComb,
  output logic              carryWeComb
);

  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] leftMask;
  logic [DATA_W-1:0] rightMask;
  logic [DATA_W-1:0] signFill;
  logic              signBit;
  logic              pickedBit;

  shift_carry_rotator #(.W(DATA_W), .IW(IDX_W)) uRot (
    .din  (operand),
    .rot  (strobes.rotRight),
    .dout (rotated)
  );

  always_comb begin
    signBit   = operand[DATA_W-1];
    leftMask  = {DATA_W{1'b1}} << strobes.maskAmt;
    rightMask = {DATA_W{1'b1}} >> strobes.maskAmt;
    signFill  = signBit ? ~rightMask : '0;
    pickedBit = operand[strobes.carryIdx];
  end

  always_comb begin
    if (strobes.passThru) begin
      resultComb = operand;
    end else if (strobes.selRot) begin
      resultComb = rotated;
    end else if (strobes.selArith) begin
      resultComb = strobes.fullOut ? {DATA_W{signBit}}
                                   : ((rotated & rightMask) | signFill);
    end else if (strobes.fullOut) begin
      resultComb = '0;
    end else if (strobes.selLeft) begin
      resultComb = rotated & leftMask;
    end else begin
      resultComb = rotated & rightMask;
    end
  end

  always_comb begin
    carryWeComb = ~strobes.passThru;
    if (strobes.passThru)      carryComb = carryIn;
    else if (strobes.carryClr) carryComb = 1'b0;
    else                       carryComb = pickedBit;
  end

endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
  import shift_carry_pkg::*;
#(
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  input  logic [1:0]        shiftType,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              carryWe
);

  shiftStrobes_t     strobes;
  logic [DATA_W-1:0] resultComb;
  logic              carryComb;
  logic              carryWeComb;

  shift_carry_ctrl #(.AMT_W(AMT_W)) uCtrl (
    .amount    (amount),
    .shiftType (shiftType),
    .strobes   (strobes)
  );

  shift_carry_datapath uPath (
    .operand     (operand),
    .carryIn     (carryIn),
    .strobes     (strobes),
    .resultComb  (resultComb),
    .carryComb   (carryComb),
    .carryWeComb (carryWeComb)
  );

  generate
    if (REG_OUT) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          result   <= '0;
          carryOut <= 1'b0;
          carryWe  <= 1'b0;
        end else begin
          result   <= resultComb;
          carryOut <= carryComb;
          carryWe  <= carryWeComb;
        end
      end
    end else begin : gComb
      assign result   = resultComb;
      assign carryOut = carryComb;
      assign carryWe  = carryWeComb;
    end
  endgenerate

endmodule

// File: rtl/shift_carry_chk.sv
module shift_carry_chk
  import shift_carry_pkg::*;
#(
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] operand,
  input logic [AMT_W-1:0]  amount,
  input logic [1:0]        shiftType,
  input logic              carryIn,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic              carryWe
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  // Inputs aligned with the outputs they produced
  logic [DATA_W-1:0] sOperand;
  logic [AMT_W-1:0]  sAmount;
  logic [1:0]        sType;
  logic              sCarry;
  logic              sValid;

  generate
    if (REG_OUT) begin : gAlign
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sOperand <= '0;
          sAmount  <= '0;
          sType    <= '0;
          sCarry   <= 1'b0;
          sValid   <= 1'b0;
        end else begin
          sOperand <= operand;
          sAmount  <= amount;
          sType    <= shiftType;
          sCarry   <= carryIn;
          sValid   <= 1'b1;
        end
      end
    end else begin : gDirect
      assign sOperand = operand;
      assign sAmount  = amount;
      assign sType    = shiftType;
      assign sCarry   = carryIn;
      assign sValid   = 1'b1;
    end
  endgenerate

  assert_zero_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sAmount == '0) |->
      (result == sOperand && carryOut == sCarry && !carryWe));

  assert_carry_we_R10: assert property (@(posedge clk) disable iff (!rstN)
    sValid |-> (carryWe == (sAmount != '0)));

  assert_lsl_exact_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sType == 2'b00 && sAmount == FULL_AMT) |->
      (result == '0 && carryOut == sOperand[0]));

  assert_lsl_over_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sType == 2'b00 && sAmount > FULL_AMT) |->
      (result == '0 && !carryOut));

  assert_lsr_exact_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sType == 2'b01 && sAmount == FULL_AMT) |->
      (result == '0 && carryOut == sOperand[DATA_W-1]));

  assert_lsr_over_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sType == 2'b01 && sAmount > FULL_AMT) |->
      (result == '0 && !carryOut));

  assert_asr_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sType == 2'b10 && sAmount >= FULL_AMT) |->
      (result == {DATA_W{sOperand[DATA_W-1]}} && carryOut == sOperand[DATA_W-1]));

  assert_ror_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sType == 2'b11 && sAmount != '0 && sAmount[IDX_W-1:0] == '0) |->
      (result == sOperand && carryOut == sOperand[DATA_W-1]));

endmodule

bind shift_carry_unit shift_carry_chk #(.AMT_W(AMT_W), .REG_OUT(REG_OUT)) uChk (.*);

// File: tb/tb_shift_carry_unit.sv
`timescale 1ns/1ps
module tb_shift_carry_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  amount = '0;
  logic [1:0]  shiftType = '0;
  logic        carryIn = 1'b0;
  logic [31:0] result;
  logic        carryOut;
  logic        carryWe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] res;
    logic        co;
    logic        we;
    string       tag;
  } expect_t;

  expect_t pending[$];

  always #2 clk = ~clk;

  shift_carry_unit dut (
    .clk(clk), .rstN(rstN), .operand(operand), .amount(amount),
    .shiftType(shiftType), .carryIn(carryIn),
    .result(result), .carryOut(carryOut), .carryWe(carryWe)
  );

  function automatic expect_t model(input logic [31:0] x, input int n,
                                    input int t, input logic c);
    expect_t e;
    int m;
    e.we = (n != 0);
    if (n == 0) begin
      e.res = x; e.co = c; e.tag = "R1";
    end else if (t == 0) begin
      if (n < 32)       begin e.res = x << n; e.co = x[32-n]; e.tag = "R2"; end
      else if (n == 32) begin e.res = 0; e.co = x[0]; e.tag = "R3"; end
      else              begin e.res = 0; e.co = 1'b0; e.tag = "R3"; end
    end else if (t == 1) begin
      if (n < 32)       begin e.res = x >> n; e.co = x[n-1]; e.tag = "R4"; end
      else if (n == 32) begin e.res = 0; e.co = x[31]; e.tag = "R5"; end
      else              begin e.res = 0; e.co = 1'b0; e.tag = "R5"; end
    end else if (t == 2) begin
      if (n < 32) begin
        e.res = 32'($signed(x) >>> n); e.co = x[n-1]; e.tag = "R6";
      end else begin
        e.res = {32{x[31]}}; e.co = x[31]; e.tag = "R7";
      end
    end else begin
      m = n % 32;
      if (m == 0) begin e.res = x; e.co = x[31]; e.tag = "R9"; end
      else begin
        e.res = (x >> m) | (x << (32 - m)); e.co = x[m-1]; e.tag = "R8";
      end
    end
    return e;
  endfunction

  task automatic compareOut(input expect_t e);
    checks++;
    if (result !== e.res || carryOut !== e.co) begin
      errors++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               e.tag, result, carryOut, e.res, e.co);
    end
    checks++;
    if (carryWe !== e.we) begin
      errors++;
      $display("FAIL R10: carryWe=%b expected %b (%s)", carryWe, e.we, e.tag);
    end
  endtask

  // One vector per cycle; the output appears one rising edge later (R11)
  task automatic applyVec(input logic [31:0] x, input int n, input int t,
                          input logic c);
    @(negedge clk);
    if (pending.size() > 0) compareOut(pending.pop_front());
    operand = x; amount = 8'(n); shiftType = 2'(t); carryIn = c;
    pending.push_back(model(x, n, t, c));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] lfsr;
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_1E69; pats[3] = 32'h0000_0000;

    // R11: reset state, inputs active but outputs held at zero
    operand = 32'hFFFF_FFFF; amount = 8'd5; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 32'h0 || carryOut !== 1'b0 || carryWe !== 1'b0) begin
      errors++;
      $display("FAIL R11: reset outputs %h/%b/%b expected 0/0/0",
               result, carryOut, carryWe);
    end
    rstN = 1'b1;

    // Directed corners for every type
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 4; p++)
        foreach (pats[k]) begin
          int amts [10] = '{0, 1, 7, 31, 32, 33, 64, 96, 224, 255};
          if (k == p)
            foreach (amts[i]) begin
              applyVec(pats[k], amts[i], t, 1'b1);
              applyVec(pats[k], amts[i], t, 1'b0);
            end
        end

    // Every amount against a pseudo-random operand
    lfsr = 32'h1357_9BDF;
    for (int n = 0; n < 256; n++)
      for (int t = 0; t < 4; t++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        applyVec(lfsr, n, t, lfsr[5]);
      end

    @(negedge clk);
    if (pending.size() > 0) compareOut(pending.pop_front());

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule